// File: doc/BRIEF.md
# Chip-Select Decoder with Wait-State Timer

This block sits between a bus front end and the external memory pins. When an access request arrives, it compares the upper address bits with the select field of each of several memory channels. One global base-address mask controls which of those bits take part in the comparison. The block raises the chip select of the winning channel and holds it while it counts wait cycles. It then gives a one-cycle acknowledge.

The number of wait cycles depends on the channel's memory kind and on fields packed into that channel's timing word. Asynchronous memory uses separate formulas for reads and writes. If no enabled channel claims the address, the block gives a one-cycle miss pulse instead.

A register bank outside the block supplies the configuration word, the timing word and the mask. The block reads them only at the moment it accepts a request.

Top module: `chipsel_waitgen`

## Requirements
- R1: Channel k claims an address when `addr[31:22] & mask` equals the zero-extended 8-bit select field (config bits [23:16]) `& mask`, where `mask` is the 10-bit `base_mask`. With a mask of zero, every enabled channel claims every address.
- R2: A channel whose config bit 0 is clear never claims an address.
- R3: When more than one enabled channel claims an address, the channel with the lowest index is selected. At most one chip select is high at any time.
- R4: For memory kind 2 (config bits [2:1] = 2), a read waits N = timing[7:0] + timing[11:8].
- R5: For memory kind 2, a write waits N = timing[15:12] + timing[19:16] + timing[25:20].
- R6: For memory kind 0, a read or a write waits N = 3 + timing[5:4].
- R7: For memory kinds 1 and 3, a read or a write waits N = 2, whatever the timing word holds.
- R8: A request is accepted on a clock edge while the block is idle. Count the cycle after that edge as cycle 1. The selected channel's `chip_sel` bit is high in cycles 1 through N+2, and `ack` is high in cycle N+2 only.
- R9: A request that no enabled channel claims gives `miss` high in cycle 1 only, with no chip select and no `ack`.
- R10: A request presented while `busy` is high is ignored. It leaves no chip select, ack or miss after the running access ends.
- R11: The chip selected and the wait count are fixed at acceptance. Later changes to the config, timing or mask inputs do not alter the running access.
- R12: Reset, whether idle or in the middle of an access, drives `chip_sel`, `ack`, `miss` and `busy` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Access address |
| base_mask | input | 10 | Mask on address bits [31:22] |
| chan_cfg | input | 256 | Eight 32-bit config words; channel k at [32k+31:32k] |
| chan_tim | input | 256 | Eight 32-bit timing words; channel k at [32k+31:32k] |
| chip_sel | output | 8 | Active-high chip selects, one bit per channel |
| ack | output | 1 | One-cycle access done |
| miss | output | 1 | One-cycle no-channel-matched pulse |
| busy | output | 1 | Access or miss in progress |

## Verification
Most faults in the latched channel or the match logic appear in the cycle right after acceptance. The port then shows the wrong `chip_sel` bit, or a `miss` where a select was due, or the reverse. A corrupted wait count does not show until later: the `ack` arrives early or late, and the error can stay hidden for up to 270 cycles on the slowest asynchronous setting. The bench therefore times the acknowledge for every memory kind and direction. It also changes the configuration mid-access to show that the count and the select were frozen at acceptance.

// File: rtl/chipsel_pkg.sv
package chipsel_pkg;

    localparam int WORD_W  = 32;
    localparam int SELF_W  = 8;
    localparam int WAIT_W  = 10;

    typedef enum logic [1:0] {
        MK_SDRAM = 2'd0,
        MK_SSRAM = 2'd1,
        MK_ASYNC = 2'd2,
        MK_SYNC  = 2'd3
    } mem_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_ACK,
        PH_MISS
    } phase_e;

    typedef struct packed {
        logic              on;
        mem_kind_e         kind;
        logic [SELF_W-1:0] sel;
    } chan_cfg_t;

    function automatic chan_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        chan_cfg_t c;
        c.on   = w[0];
        c.kind = mem_kind_e'(w[2:1]);
        c.sel  = w[23:16];
        return c;
    endfunction

    function automatic logic [WAIT_W-1:0] wait_count(input mem_kind_e k,
                                                     input logic [WORD_W-1:0] t,
                                                     input logic wr);
        logic [WAIT_W-1:0] n;
        unique case (k)
            MK_ASYNC: begin
                if (wr)
                    n = WAIT_W'(t[15:12]) + WAIT_W'(t[19:16]) + WAIT_W'(t[25:20]);
                else
                    n = WAIT_W'(t[7:0]) + WAIT_W'(t[11:8]);
            end
            MK_SDRAM: n = WAIT_W'(3) + WAIT_W'(t[5:4]);
            default:  n = WAIT_W'(2);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/chipsel_match.sv
module chipsel_match
    import chipsel_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int AW    = 32,
    parameter int MASKW = 10
) (
    input  logic [AW-1:0]         addr,
    input  logic [MASKW-1:0]      mask,
    input  logic [NCH*WORD_W-1:0] cfg_flat,
    output logic [NCH-1:0]        hit
);
    localparam int SHIFT = AW - MASKW;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        chan_cfg_t        c;
        logic [MASKW-1:0] sel_ext;
        assign c       = unpack_cfg(cfg_flat[g*WORD_W +: WORD_W]);
        assign sel_ext = MASKW'(c.sel);
        assign hit[g]  = c.on && (((addr[AW-1:SHIFT] ^ sel_ext) & mask) == '0);
    end
endmodule

// File: rtl/chipsel_prio.sv
module chipsel_prio #(
    parameter int NCH = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] hit,
    output logic           found,
    output logic [IW-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/chipsel_wscalc.sv
module chipsel_wscalc
    import chipsel_pkg::*;
(
    input  logic [WORD_W-1:0] cfg,
    input  logic [WORD_W-1:0] tim,
    input  logic              wr,
    output logic [WAIT_W-1:0] n
);
    chan_cfg_t c;
    assign c = unpack_cfg(cfg);
    assign n = wait_count(c.kind, tim, wr);
endmodule

// File: rtl/chipsel_waitgen.sv
module chipsel_waitgen
    import chipsel_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int AW    = 32,
    parameter int MASKW = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [AW-1:0]         req_addr,
    input  logic [MASKW-1:0]      base_mask,
    input  logic [NCH*WORD_W-1:0] chan_cfg,
    input  logic [NCH*WORD_W-1:0] chan_tim,
    output logic [NCH-1:0]        chip_sel,
    output logic                  ack,
    output logic                  miss,
    output logic                  busy
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0]    hit;
    logic              found;
    logic [IW-1:0]     idx;
    logic [WAIT_W-1:0] n_new;

    phase_e            phase;
    logic [NCH-1:0]    cur_sel;
    logic [WAIT_W-1:0] cnt;

    chipsel_match #(.NCH(NCH), .AW(AW), .MASKW(MASKW)) u_match (
        .addr     (req_addr),
        .mask     (base_mask),
        .cfg_flat (chan_cfg),
        .hit      (hit)
    );

    chipsel_prio #(.NCH(NCH)) u_prio (
        .hit   (hit),
        .found (found),
        .idx   (idx)
    );

    chipsel_wscalc u_ws (
        .cfg (chan_cfg[idx*WORD_W +: WORD_W]),
        .tim (chan_tim[idx*WORD_W +: WORD_W]),
        .wr  (req_write),
        .n   (n_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cur_sel <= '0;
            cnt     <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        if (found) begin
                            phase   <= PH_WAIT;
                            cur_sel <= NCH'(1) << idx;
                            cnt     <= n_new;
                        end else begin
                            phase <= PH_MISS;
                        end
                    end
                end
                PH_WAIT: begin
                    if (cnt == '0) phase <= PH_ACK;
                    else           cnt   <= cnt - WAIT_W'(1);
                end
                PH_ACK:  phase <= PH_IDLE;
                PH_MISS: phase <= PH_IDLE;
            endcase
        end
    end

    assign chip_sel = (phase == PH_WAIT || phase == PH_ACK) ? cur_sel : '0;
    assign ack      = (phase == PH_ACK);
    assign miss     = (phase == PH_MISS);
    assign busy     = (phase != PH_IDLE);
endmodule

// File: rtl/chipsel_waitgen_chk.sv
module chipsel_waitgen_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] chip_sel,
    input logic           ack,
    input logic           miss,
    input logic           busy
);
    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chip_sel));

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_ack_with_sel_R8: assert property (@(posedge clk) disable iff (rst)
        ack |-> ($countones(chip_sel) == 1 && busy));

    assert_miss_clean_R9: assert property (@(posedge clk) disable iff (rst)
        miss |-> (chip_sel == '0 && !ack && busy));

    assert_miss_single_R9: assert property (@(posedge clk) disable iff (rst)
        miss |=> !miss);

    assert_sel_drop_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> (chip_sel == '0 && !busy));

    assert_sel_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (|chip_sel && !ack) |=> (chip_sel == $past(chip_sel)));

    assert_reset_idle_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chip_sel == '0 && !ack && !miss && !busy));
endmodule

bind chipsel_waitgen chipsel_waitgen_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .chip_sel (chip_sel),
    .ack      (ack),
    .miss     (miss),
    .busy     (busy)
);

// File: tb/chipsel_waitgen_test.sv
module chipsel_waitgen_test;
    localparam int NCH = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [31:0]       req_addr = '0;
    logic [9:0]        base_mask = 10'h3FF;
    logic [31:0]       cfg [NCH];
    logic [31:0]       tim [NCH];
    logic [NCH*32-1:0] cfg_flat;
    logic [NCH*32-1:0] tim_flat;
    logic [NCH-1:0]    chip_sel;
    logic              ack, miss, busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cfg_flat[i*32 +: 32] = cfg[i];
            tim_flat[i*32 +: 32] = tim[i];
        end
    end

    chipsel_waitgen uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .base_mask (base_mask),
        .chan_cfg  (cfg_flat),
        .chan_tim  (tim_flat),
        .chip_sel  (chip_sel),
        .ack       (ack),
        .miss      (miss),
        .busy      (busy)
    );

    function automatic logic [31:0] mk_cfg(input logic en, input logic [1:0] kind,
                                           input logic [7:0] sel);
        return {8'h00, sel, 13'h0000, kind, en};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // {addr[31:0], wr, hit, ch[2:0], n[8:0]}
    localparam logic [45:0] VEC [12] = '{
        {32'h0040_1234, 1'b0, 1'b1, 3'd0, 9'd5},
        {32'h0040_0000, 1'b1, 1'b1, 3'd0, 9'd5},
        {32'h0080_0010, 1'b0, 1'b1, 3'd1, 9'd13},
        {32'h0080_0010, 1'b1, 1'b1, 3'd1, 9'd29},
        {32'h00C0_0000, 1'b0, 1'b1, 3'd2, 9'd2},
        {32'h0100_0000, 1'b1, 1'b1, 3'd3, 9'd2},
        {32'h0140_0000, 1'b0, 1'b0, 3'd0, 9'd0},
        {32'h0180_0000, 1'b0, 1'b1, 3'd6, 9'd3},
        {32'h01C0_0000, 1'b0, 1'b1, 3'd7, 9'd270},
        {32'h01C0_0000, 1'b1, 1'b1, 3'd7, 9'd93},
        {32'h4040_0000, 1'b0, 1'b0, 3'd0, 9'd0},
        {32'h0200_0000, 1'b1, 1'b0, 3'd0, 9'd0}
    };

    // disturb: 0 none, 1 request while busy, 2 rewrite channel 7 mid-access
    task automatic access(input logic [31:0] a, input logic w, input logic exp_hit,
                          input int exp_ch, input int exp_n, input string rq,
                          input int disturb);
        int ack_at;
        int bad_sel;
        @(negedge clk);
        req_addr = a; req_write = w; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!exp_hit) begin
            chk(miss === 1'b1, rq, "miss in cycle 1", miss, 1);
            chk(chip_sel === '0, rq, "no select on miss", chip_sel, 0);
            @(negedge clk);
            chk(miss === 1'b0 && ack === 1'b0, rq, "miss lasts one cycle", miss, 0);
        end else begin
            ack_at  = -1;
            bad_sel = 0;
            for (int c = 1; c <= exp_n + 8; c++) begin
                if (chip_sel !== (8'(1) << exp_ch)) bad_sel++;
                if (ack === 1'b1) begin
                    ack_at = c;
                    break;
                end
                if (disturb == 1 && c == 2) begin
                    req_addr = 32'h00C0_0000; req_valid = 1'b1;
                end
                if (disturb == 1 && c == 5) req_valid = 1'b0;
                if (disturb == 2 && c == 3) begin
                    tim[7] = 32'h0; cfg[7] = 32'h0; base_mask = 10'h000;
                end
                @(negedge clk);
            end
            chk(ack_at == exp_n + 2, rq, "ack cycle", ack_at, exp_n + 2);
            chk(bad_sel == 0, rq, "select cycles wrong", bad_sel, 0);
            @(negedge clk);
            chk(chip_sel === '0 && ack === 1'b0, rq, "select released", chip_sel, 0);
        end
    endtask

    task automatic setup_regs();
        base_mask = 10'h3FF;
        cfg[0] = mk_cfg(1'b1, 2'd0, 8'h01); tim[0] = 32'h0000_0020;
        cfg[1] = mk_cfg(1'b1, 2'd2, 8'h02); tim[1] = 32'h0145_430A;
        cfg[2] = mk_cfg(1'b1, 2'd1, 8'h03); tim[2] = 32'hFFFF_FFFF;
        cfg[3] = mk_cfg(1'b1, 2'd3, 8'h04); tim[3] = 32'hFFFF_FFFF;
        cfg[4] = mk_cfg(1'b0, 2'd2, 8'h05); tim[4] = 32'h0000_0000;
        cfg[5] = mk_cfg(1'b1, 2'd2, 8'h02); tim[5] = 32'h0000_0000;
        cfg[6] = mk_cfg(1'b1, 2'd0, 8'h06); tim[6] = 32'h0000_0000;
        cfg[7] = mk_cfg(1'b1, 2'd2, 8'h07); tim[7] = 32'h03FF_FFFF;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        setup_regs();
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(chip_sel === '0 && ack === 0 && miss === 0 && busy === 0,
            "R12", "outputs in reset", {chip_sel, ack, miss, busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R12", "idle after reset", busy, 0);

        // Vector table: R1 R2 R4 R5 R6 R7 R8 R9 (ch4 disabled -> R2, sel 2 dup -> R3)
        for (int v = 0; v < 12; v++) begin
            access(VEC[v][45:14], VEC[v][13], VEC[v][12], int'(VEC[v][11:9]),
                   int'(VEC[v][8:0]), $sformatf("R8 vec%0d", v), 0);
        end

        // R1 R3: zero mask lets every enabled channel match, lowest wins
        base_mask = 10'h000;
        access(32'h4140_0000, 1'b0, 1'b1, 0, 5, "R1 zero mask", 0);
        // R1: mask ignores addr[23:22]
        base_mask = 10'h3FC;
        access(32'h00C0_0000, 1'b1, 1'b1, 0, 5, "R1 partial mask", 0);
        // R2 R3: ch3 and disabled ch4 both compare equal, ch3 wins
        access(32'h0140_0000, 1'b0, 1'b1, 3, 2, "R2 disabled skipped", 0);
        base_mask = 10'h3FF;

        // R10: request while busy is ignored
        access(32'h0080_0000, 1'b0, 1'b1, 1, 13, "R10 busy request", 1);
        repeat (3) begin
            chk(chip_sel === '0 && miss === 0 && ack === 0, "R10", "no trace of ignored request",
                chip_sel, 0);
            @(negedge clk);
        end

        // R11: registers rewritten mid-access
        access(32'h01C0_0000, 1'b0, 1'b1, 7, 270, "R11 frozen access", 2);
        setup_regs();

        // R12: reset in the middle of an access
        @(negedge clk);
        req_addr = 32'h01C0_0000; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(chip_sel === 8'h80, "R12", "select before mid reset", chip_sel, 8'h80);
        rst = 1'b1;
        @(negedge clk);
        chk(chip_sel === '0 && ack === 0 && busy === 0, "R12", "mid-access reset",
            {chip_sel, busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        access(32'h00C0_0000, 1'b0, 1'b1, 2, 2, "R7 after reset", 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule